// File: doc/BRIEF.md
# Snooping Invalidate Coherence Controller

This block keeps several small processor caches coherent over one shared bus and one shared memory. Each cache has its own agent. The agent serves the processor's loads and stores from a handful of direct-mapped, one-word lines. Each line is Invalid, Shared or Modified. When the line's state is not enough to complete an access, the agent requests the bus. A round-robin arbiter grants exactly one request per cycle, so all bus traffic, and with it every write to a given address, is put into one order that every agent sees.

Every agent watches every granted transaction and updates its own copy of the addressed line. A cache gains exclusive ownership before it writes. Ownership comes from an invalidate when the cache already has the data, or from a read-exclusive when it does not. Any other copy is dropped. When a later read miss names a line that another cache holds Modified, that owner drives the data onto the bus instead of memory. The same value is written into memory, and the owner keeps a Shared copy. A registered trace of each bus transaction appears on the top-level outputs one cycle after it occurs.

A processor holds its request, with its address, write flag and data, until its done pulse. Hits finish on the clock edge after the request. Misses finish on the edge that ends their granted transaction.

Top module: `snoop_coherence_system`

## Requirements
- R1: After reset, every line of every agent is Invalid, memory reads as zero, and `cpu_done` and `trc_valid` are low. The first access to any address therefore goes to the bus.
- R2: A read of a line that is not present issues a bus read (trace op code 1) and fills the line as Shared. A second read of that address by the same agent completes with no bus transaction. The trace op codes are 0 none, 1 read, 2 read-exclusive, 3 invalidate, 4 writeback.
- R3: A write to a line that is not present issues a read-exclusive (op 2) and leaves the line Modified. Further writes and reads of it by the same agent use no bus transaction.
- R4: A write to a line held Shared issues only an invalidate (op 3). No data fetch is issued.
- R5: When an agent sees another agent's invalidate or read-exclusive for an address it holds, it drops its copy. Its next read of that address misses and issues a bus read.
- R6: A read or read-exclusive that names a line another agent holds Modified is answered by that owner (`trc_owner`=1, trace data = owner's value). On a read, memory takes the value and the owner moves to Shared, so a third agent later reads the value from memory (`trc_owner`=0).
- R7: At most one request is granted per cycle, and only to a requesting agent. Priority rotates to the agent after the last one granted, and it starts at agent 0 after reset.
- R8: A miss whose line index holds a Modified line with another tag first issues a writeback (op 4) carrying the victim's address and data. The fetch follows. Memory then holds the victim's value.
- R9: `cpu_done` is a single-cycle pulse. On a read it comes with the read word on `cpu_rdata`.
- R10: Writes to one address by several agents take effect in bus grant order. Every agent afterwards reads the value of the last granted writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | NUM_AGENTS | Per-agent access request, held until done |
| cpu_we | input | NUM_AGENTS | Per-agent write flag |
| cpu_addr | input | NUM_AGENTS*ADDR_W | Per-agent word address, agent i in slice i |
| cpu_wdata | input | NUM_AGENTS*DATA_W | Per-agent write word |
| cpu_done | output | NUM_AGENTS | Per-agent completion pulse |
| cpu_rdata | output | NUM_AGENTS*DATA_W | Per-agent returned word |
| trc_valid | output | 1 | A bus transaction took place in the previous cycle |
| trc_op | output | 3 | Op code of that transaction |
| trc_src | output | SRC_W | Agent that issued it |
| trc_addr | output | ADDR_W | Its address |
| trc_data | output | DATA_W | Word that was on the bus |
| trc_owner | output | 1 | Data came from an owning cache, not memory |

## Verification
Single-agent read and write sequences on one address walk a line through all three states. Because each step must give exactly one op code, or none, on the trace, the sequences separate a hit from a miss and an upgrade from a read-exclusive. A sweep over every address and every writer/reader rotation has one cache write, a second cache read and a third cache read. This sets owner intervention (owner flag set, fresh data) apart from a memory reply that must already hold the written-back value. Simultaneous requests from all agents, issued first from a reset priority pointer and then from a rotated one, show the grant order on the trace. They also tell round-robin from fixed priority, because the final value of a contested address differs between the two.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_MOD = 2'b10
  } line_state_e;

  typedef enum logic [2:0] {
    BOP_NONE = 3'd0,
    BOP_RD   = 3'd1,
    BOP_RDX  = 3'd2,
    BOP_INV  = 3'd3,
    BOP_WB   = 3'd4
  } bus_op_e;

endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N = 3,
  localparam int SRC_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [SRC_W-1:0] gidx,
  output logic             any
);

  logic [SRC_W-1:0] ptr_q;

  function automatic int wrap_idx(int base, int step);
    int s;
    s = base + step;
    if (s >= N) s = s - N;
    return s;
  endfunction

  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[wrap_idx(int'(ptr_q), k)]) begin
        grant[wrap_idx(int'(ptr_q), k)] = 1'b1;
        gidx = SRC_W'(wrap_idx(int'(ptr_q), k));
        any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (any) begin
      ptr_q <= (gidx == SRC_W'(N - 1)) ? '0 : gidx + SRC_W'(1);
    end
  end

endmodule

// File: rtl/coh_shared_mem.sv
module coh_shared_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

endmodule

// File: rtl/coh_agent.sv
module coh_agent
  import coh_pkg::*;
#(
  parameter int AGENT_ID = 0,
  parameter int N        = 3,
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 2,
  parameter int DATA_W   = 8,
  localparam int SRC_W   = (N > 1) ? $clog2(N) : 1,
  localparam int LINES   = 1 << IDX_W,
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output bus_op_e           req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              grant,
  input  logic              snp_valid,
  input  bus_op_e           snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [DATA_W-1:0] fill_data,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data
);

  line_state_e       st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  line_state_e      c_st, s_st;
  logic             c_present, from_other, s_hit, collide, active, local_hit;

  assign c_idx     = cpu_addr[IDX_W-1:0];
  assign c_tag     = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st      = st_q[c_idx];
  assign c_present = (c_st != LS_INV) && (tag_q[c_idx] == c_tag);

  assign s_idx      = snp_addr[IDX_W-1:0];
  assign s_tag      = snp_addr[ADDR_W-1:IDX_W];
  assign s_st       = st_q[s_idx];
  assign from_other = snp_valid && (snp_src != SRC_W'(AGENT_ID));
  assign s_hit      = from_other && (s_st != LS_INV) && (tag_q[s_idx] == s_tag);

  // owner intervention on reads and read-exclusives
  assign supply      = s_hit && (s_st == LS_MOD) &&
                       ((snp_op == BOP_RD) || (snp_op == BOP_RDX));
  assign supply_data = dat_q[s_idx];

  // a local hit waits one cycle if another agent's transaction touches the same line
  assign collide = from_other && (s_idx == c_idx);
  assign active  = cpu_req && !cpu_done;

  // op chosen from the line state at the moment of the request
  always_comb begin
    req_op   = BOP_NONE;
    req_addr = cpu_addr;
    req_data = dat_q[c_idx];
    if (c_present) begin
      if (cpu_we && (c_st == LS_SHR)) req_op = BOP_INV;
    end else if (c_st == LS_MOD) begin
      req_op   = BOP_WB;
      req_addr = {tag_q[c_idx], c_idx};
    end else begin
      req_op = cpu_we ? BOP_RDX : BOP_RD;
    end
  end

  assign bus_req   = active && (req_op != BOP_NONE);
  assign local_hit = active && (req_op == BOP_NONE) && !collide;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;

      if (s_hit) begin
        case (snp_op)
          BOP_RD:           if (s_st == LS_MOD) st_q[s_idx] <= LS_SHR;
          BOP_RDX, BOP_INV: st_q[s_idx] <= LS_INV;
          default:          ;
        endcase
      end

      if (local_hit) begin
        cpu_done <= 1'b1;
        if (cpu_we) begin
          dat_q[c_idx] <= cpu_wdata;
          cpu_rdata    <= cpu_wdata;
        end else begin
          cpu_rdata <= dat_q[c_idx];
        end
      end

      if (grant) begin
        case (req_op)
          BOP_WB: st_q[c_idx] <= LS_INV;
          BOP_RD: begin
            st_q[c_idx]  <= LS_SHR;
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= fill_data;
            cpu_rdata    <= fill_data;
            cpu_done     <= 1'b1;
          end
          BOP_RDX, BOP_INV: begin
            st_q[c_idx]  <= LS_MOD;
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= cpu_wdata;
            cpu_rdata    <= cpu_wdata;
            cpu_done     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/snoop_coherence_system.sv
module snoop_coherence_system
  import coh_pkg::*;
#(
  parameter int NUM_AGENTS = 3,
  parameter int ADDR_W     = 4,
  parameter int IDX_W      = 2,
  parameter int DATA_W     = 8,
  localparam int SRC_W     = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_AGENTS-1:0]        cpu_req,
  input  logic [NUM_AGENTS-1:0]        cpu_we,
  input  logic [NUM_AGENTS*ADDR_W-1:0] cpu_addr,
  input  logic [NUM_AGENTS*DATA_W-1:0] cpu_wdata,
  output logic [NUM_AGENTS-1:0]        cpu_done,
  output logic [NUM_AGENTS*DATA_W-1:0] cpu_rdata,
  output logic                         trc_valid,
  output logic [2:0]                   trc_op,
  output logic [SRC_W-1:0]             trc_src,
  output logic [ADDR_W-1:0]            trc_addr,
  output logic [DATA_W-1:0]            trc_data,
  output logic                         trc_owner
);

  logic [NUM_AGENTS-1:0] bus_req_vec, grant_vec, supply_vec;
  bus_op_e               req_op_a      [NUM_AGENTS];
  logic [ADDR_W-1:0]     req_addr_a    [NUM_AGENTS];
  logic [DATA_W-1:0]     req_data_a    [NUM_AGENTS];
  logic [DATA_W-1:0]     supply_data_a [NUM_AGENTS];

  logic [SRC_W-1:0]  gidx;
  logic              bus_any, owner_hit, mem_we;
  bus_op_e           bus_op;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, owner_data, mem_rdata, bus_data, mem_wdata;

  coh_rr_arbiter #(.N(NUM_AGENTS)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (bus_req_vec),
    .grant (grant_vec),
    .gidx  (gidx),
    .any   (bus_any)
  );

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
    coh_agent #(
      .AGENT_ID (g),
      .N        (NUM_AGENTS),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .DATA_W   (DATA_W)
    ) u_agent (
      .clk         (clk),
      .rst         (rst),
      .cpu_req     (cpu_req[g]),
      .cpu_we      (cpu_we[g]),
      .cpu_addr    (cpu_addr[g*ADDR_W +: ADDR_W]),
      .cpu_wdata   (cpu_wdata[g*DATA_W +: DATA_W]),
      .cpu_done    (cpu_done[g]),
      .cpu_rdata   (cpu_rdata[g*DATA_W +: DATA_W]),
      .bus_req     (bus_req_vec[g]),
      .req_op      (req_op_a[g]),
      .req_addr    (req_addr_a[g]),
      .req_data    (req_data_a[g]),
      .grant       (grant_vec[g]),
      .snp_valid   (bus_any),
      .snp_op      (bus_op),
      .snp_addr    (bus_addr),
      .snp_src     (gidx),
      .fill_data   (bus_data),
      .supply      (supply_vec[g]),
      .supply_data (supply_data_a[g])
    );
  end

  assign bus_op    = bus_any ? req_op_a[gidx] : BOP_NONE;
  assign bus_addr  = req_addr_a[gidx];
  assign bus_wdata = req_data_a[gidx];

  always_comb begin
    owner_data = '0;
    for (int i = 0; i < NUM_AGENTS; i++) begin
      if (supply_vec[i]) owner_data = owner_data | supply_data_a[i];
    end
  end

  assign owner_hit = |supply_vec;
  assign bus_data  = owner_hit ? owner_data :
                     ((bus_op == BOP_WB) ? bus_wdata : mem_rdata);
  assign mem_we    = (bus_op == BOP_WB) || ((bus_op == BOP_RD) && owner_hit);
  assign mem_wdata = (bus_op == BOP_WB) ? bus_wdata : owner_data;

  coh_shared_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .addr  (bus_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trc_valid <= 1'b0;
      trc_op    <= 3'd0;
      trc_src   <= '0;
      trc_addr  <= '0;
      trc_data  <= '0;
      trc_owner <= 1'b0;
    end else begin
      trc_valid <= bus_any;
      trc_op    <= bus_op;
      trc_src   <= gidx;
      trc_addr  <= bus_addr;
      trc_data  <= bus_data;
      trc_owner <= owner_hit;
    end
  end

endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic [N-1:0] supply,
  input logic [N-1:0] done,
  input logic         trc_valid,
  input logic [2:0]   trc_op,
  input logic         trc_owner
);

  a_r7_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);

  a_r7_grant_traced: assert property (@(posedge clk) disable iff (rst)
    (|grant) |=> trc_valid);

  a_r6_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(supply));

  a_r6_owner_on_fetch: assert property (@(posedge clk) disable iff (rst)
    trc_owner |-> (trc_valid && (trc_op == 3'd1 || trc_op == 3'd2)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done & $past(done)) == '0);

  a_r2_legal_op: assert property (@(posedge clk) disable iff (rst)
    trc_valid |-> (trc_op != 3'd0 && trc_op <= 3'd4));

endmodule

bind snoop_coherence_system coh_checker #(.N(NUM_AGENTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (bus_req_vec),
  .grant     (grant_vec),
  .supply    (supply_vec),
  .done      (cpu_done),
  .trc_valid (trc_valid),
  .trc_op    (trc_op),
  .trc_owner (trc_owner)
);

// File: tb/snoop_coherence_system_test.sv
`timescale 1ns/1ps
module snoop_coherence_system_test;
  localparam int N = 3, AW = 4, IW = 2, DW = 8, SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    cpu_req = '0, cpu_we = '0;
  logic [N*AW-1:0] cpu_addr = '0;
  logic [N*DW-1:0] cpu_wdata = '0;
  logic [N-1:0]    cpu_done;
  logic [N*DW-1:0] cpu_rdata;
  logic            trc_valid, trc_owner;
  logic [2:0]      trc_op;
  logic [SW-1:0]   trc_src;
  logic [AW-1:0]   trc_addr;
  logic [DW-1:0]   trc_data;

  always #2.5 clk = ~clk;

  snoop_coherence_system #(.NUM_AGENTS(N), .ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .trc_valid(trc_valid), .trc_op(trc_op), .trc_src(trc_src), .trc_addr(trc_addr),
    .trc_data(trc_data), .trc_owner(trc_owner)
  );

  int checks = 0, failures = 0;
  int lg_op [256], lg_src [256], lg_addr [256], lg_data [256], lg_own [256];
  int lg_n = 0;
  int o_start = 0, o_cnt = 0, o_rdata = 0;
  int cr [N];
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lop(int k);  return lg_op[(o_start + k) % 256];  endfunction
  function automatic int lsrc(int k); return lg_src[(o_start + k) % 256]; endfunction
  function automatic int ladr(int k); return lg_addr[(o_start + k) % 256]; endfunction
  function automatic int ldat(int k); return lg_data[(o_start + k) % 256]; endfunction
  function automatic int lown(int k); return lg_own[(o_start + k) % 256]; endfunction

  // trace monitor, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (trc_valid) begin
      lg_op[lg_n % 256]   = int'(trc_op);
      lg_src[lg_n % 256]  = int'(trc_src);
      lg_addr[lg_n % 256] = int'(trc_addr);
      lg_data[lg_n % 256] = int'(trc_data);
      lg_own[lg_n % 256]  = int'(trc_owner);
      lg_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_op(int a, bit we, int addr, int d);
    @(negedge clk);
    o_start = lg_n;
    cpu_req[a] = 1'b1;
    cpu_we[a]  = we;
    cpu_addr[a*AW +: AW]  = AW'(addr);
    cpu_wdata[a*DW +: DW] = DW'(d);
    do @(negedge clk); while (!cpu_done[a]);
    o_rdata = int'(cpu_rdata[a*DW +: DW]);
    cpu_req[a] = 1'b0;
    o_cnt = lg_n - o_start;
  endtask

  task automatic conc(bit we, int a0, int a1, int a2, int d0, int d1, int d2);
    logic [N-1:0] pend;
    int ad [N];
    int dd [N];
    ad[0] = a0; ad[1] = a1; ad[2] = a2;
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    @(negedge clk);
    o_start = lg_n;
    for (int a = 0; a < N; a++) begin
      cpu_req[a] = 1'b1;
      cpu_we[a]  = we;
      cpu_addr[a*AW +: AW]  = AW'(ad[a]);
      cpu_wdata[a*DW +: DW] = DW'(dd[a]);
    end
    pend = '1;
    while (pend != '0) begin
      @(negedge clk);
      for (int a = 0; a < N; a++) begin
        if (pend[a] && cpu_done[a]) begin
          cr[a] = int'(cpu_rdata[a*DW +: DW]);
          cpu_req[a] = 1'b0;
          pend[a] = 1'b0;
        end
      end
    end
    o_cnt = lg_n - o_start;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 done low after reset", int'(cpu_done), 0);
    chk("R1 no trace after reset", int'(trc_valid), 0);

    // cold read: miss goes to the bus, memory is zero
    do_op(0, 0, 5, 0);
    chk("R1 cold read uses bus", o_cnt, 1);
    chk("R2 read miss op", lop(0), 1);
    chk("R1 memory zero", o_rdata, 0);
    chk("R2 no owner on cold read", lown(0), 0);
    do_op(0, 0, 5, 0);
    chk("R2 read hit no bus", o_cnt, 0);
    chk("R2 read hit data", o_rdata, 0);
    @(negedge clk);
    chk("R9 done is one pulse", int'(cpu_done[0]), 0);

    // write miss
    do_op(1, 1, 5, 8'hA5);
    chk("R3 write miss count", o_cnt, 1);
    chk("R3 write miss op", lop(0), 2);
    chk("R3 write miss source", lsrc(0), 1);
    do_op(1, 1, 5, 8'hA6);
    chk("R3 write hit on Modified no bus", o_cnt, 0);
    do_op(1, 0, 5, 0);
    chk("R3 read hit on Modified no bus", o_cnt, 0);
    chk("R9 read returns word", o_rdata, 8'hA6);

    // agent 0 was invalidated; owner intervention
    do_op(0, 0, 5, 0);
    chk("R5 invalidated copy misses", o_cnt, 1);
    chk("R5 miss op", lop(0), 1);
    chk("R6 owner supplies", lown(0), 1);
    chk("R6 owner data on bus", ldat(0), 8'hA6);
    chk("R6 reader gets owner data", o_rdata, 8'hA6);

    // owner now Shared: write is an upgrade only
    do_op(1, 1, 5, 8'h11);
    chk("R4 upgrade count", o_cnt, 1);
    chk("R4 upgrade is invalidate", lop(0), 3);
    do_op(0, 0, 5, 0);
    chk("R5 miss after invalidate", o_cnt, 1);
    chk("R6 owner supplies new value", o_rdata, 8'h11);
    do_op(2, 0, 5, 0);
    chk("R6 memory written back", lown(0), 0);
    chk("R6 memory value", o_rdata, 8'h11);

    // shared upgrade, then conflict eviction of a Modified victim
    do_op(2, 0, 6, 0);
    do_op(2, 1, 6, 8'h22);
    chk("R4 count", o_cnt, 1);
    chk("R4 op", lop(0), 3);
    chk("R4 address", ladr(0), 6);
    do_op(2, 1, 10, 8'h33);
    chk("R8 two transactions", o_cnt, 2);
    chk("R8 writeback first", lop(0), 4);
    chk("R8 victim address", ladr(0), 6);
    chk("R8 victim data", ldat(0), 8'h22);
    chk("R8 then fetch", lop(1), 2);
    chk("R8 fetch address", ladr(1), 10);
    do_op(0, 0, 6, 0);
    chk("R8 memory holds victim", o_rdata, 8'h22);
    chk("R8 served by memory", lown(0), 0);
    do_op(1, 0, 10, 0);
    chk("R6 owner of new line", lown(0), 1);
    chk("R6 new line data", o_rdata, 8'h33);

    // sweep: every address, every writer/reader rotation
    for (int ad = 0; ad < 16; ad++) begin
      for (int w = 0; w < N; w++) begin
        int v;
        v = (ad * 16 + w * 5 + 1) % 256;
        do_op(w, 1, ad, v);
        do_op((w + 1) % N, 0, ad, 0);
        chk("R6 sweep owner read data", o_rdata, v);
        chk("R6 sweep owner flag", lg_own[(lg_n - 1) % 256], 1);
        do_op((w + 2) % N, 0, ad, 0);
        chk("R10 sweep third reader data", o_rdata, v);
        chk("R6 sweep memory flag", lg_own[(lg_n - 1) % 256], 0);
      end
    end

    // arbitration
    do_reset();
    conc(1'b0, 1, 2, 3, 0, 0, 0);
    chk("R7 three grants", o_cnt, 3);
    chk("R7 first grant", lsrc(0), 0);
    chk("R7 second grant", lsrc(1), 1);
    chk("R7 third grant", lsrc(2), 2);
    do_op(0, 0, 8, 0);
    conc(1'b1, 7, 7, 7, 8'h70, 8'h71, 8'h72);
    chk("R7 rotated count", o_cnt, 3);
    chk("R7 rotated first", lsrc(0), 1);
    chk("R7 rotated second", lsrc(1), 2);
    chk("R7 rotated third", lsrc(2), 0);
    chk("R10 each write is read-exclusive", lop(0) + lop(1) + lop(2), 6);
    chk("R10 later writer fetches from owner", lown(1), 1);
    do_op(1, 0, 7, 0);
    chk("R10 last granted writer wins a1", o_rdata, 8'h70);
    do_op(2, 0, 7, 0);
    chk("R10 last granted writer wins a2", o_rdata, 8'h70);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule